// File: doc/BRIEF.md
# Half-Duplex Transmit Keying Controller

This block decides when a packet-radio transmitter may key up and then runs one keyed transmission from start to finish. While a frame is waiting and the channel is shared (half duplex), it applies a p-persistent access rule on slot ticks. A busy carrier pushes the attempt back. When a slot counter expires, the attempt proceeds only if a random byte supplied from outside does not exceed the persistence setting. With full duplex selected, the frame goes out at once.

A transmission asserts the key output and sends a preamble of 0x7E flag bytes. It then passes framed bytes from an upstream framer straight through to a byte sink, and after the last frame it sends a tail of flag bytes. Preamble and tail lengths are set in 10 ms units and converted to byte counts from the bit rate. Frames that follow one another, or that arrive during the tail, are sent in the same keyed period. The key drops only after the tail is done and the modem reports that its transmitter is off. A calibration count makes the idle controller send zero bytes, and these take precedence over starting a frame.

Top module: `tx_key_ctrl`

## Requirements
- R1: After reset the key output is low, no byte is offered, the key-up counter is 0, and the channel settings are: preamble 20, tail 2, slot time 10, persistence 40, half duplex.
- R2: In half duplex with a frame offered and the controller idle, a high `chan_busy` blocks key-up and reloads the slot counter with the slot time on every such cycle.
- R3: With the channel clear, each `slot_tick` decrements the slot counter. The tick that finds the counter at 1 or below reloads it, and keys up only if `rnd_val` is less than or equal to the persistence setting (both unsigned 8-bit).
- R4: In full duplex, a frame offered while idle keys up on the next clock edge, ignoring `chan_busy` and `slot_tick`.
- R5: Key-up first sends floor(preamble × `bit_rate` / 800) bytes of 0x7E; a count of zero sends no preamble and goes straight to data.
- R6: In data, framer bytes are passed through unchanged, in order. A pause in the framer before the byte marked `frm_last` inserts nothing and does not end the transmission. A frame offered right after another frame's last byte follows with no flags in between.
- R7: When no frame is offered after a frame's last byte, the controller sends floor(tail × `bit_rate` / 800) bytes of 0x7E.
- R8: A frame offered during the tail ends the tail and is passed through in the same keyed period, without a new key-up.
- R9: The key output stays high until the tail count is used up and `ptt_fb` is low; the controller then returns to idle on the next clock edge.
- R10: While idle with a nonzero calibration count, the controller sends a 0x00 byte per accepted transfer and decrements the count. It does not key up until the count reaches 0.
- R11: `keyup_count` increments by one on each key-up and at no other time.
- R12: A write of the channel settings (`cfg_we`) sets the slot counter to 1, so the next clear-channel tick makes an access decision.
- R13: `out_valid` is high only while `out_space` is high. Each cycle with `out_valid` high transfers one byte; `frm_ready` marks a framer byte taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_busy | input | 1 | Carrier detected on the channel (1 = busy) |
| ptt_fb | input | 1 | Modem reports transmitter still keyed |
| slot_tick | input | 1 | One-cycle pulse per access slot |
| rnd_val | input | 8 | Random byte for the persistence draw |
| cfg_we | input | 1 | Load the channel settings below |
| cfg_txdelay | input | 8 | Preamble length in 10 ms units |
| cfg_txtail | input | 8 | Tail length in 10 ms units |
| cfg_slottime | input | 8 | Slot counter reload value |
| cfg_persist | input | 8 | Persistence threshold |
| cfg_fulldup | input | 1 | 1 = full duplex |
| bit_rate | input | 20 | Line bit rate in bit/s |
| cal_we | input | 1 | Load the calibration byte count |
| cal_bytes | input | 16 | Number of zero bytes for calibration |
| frm_valid | input | 1 | Framer offers a byte |
| frm_data | input | 8 | Framer byte |
| frm_last | input | 1 | Offered byte ends its frame |
| frm_ready | output | 1 | Framer byte taken this cycle |
| out_space | input | 1 | Sink can take a byte this cycle |
| out_valid | output | 1 | Byte transferred to the sink this cycle |
| out_data | output | 8 | Byte to the sink |
| ptt | output | 1 | Transmitter key |
| keyup_count | output | 16 | Number of key-ups since reset |

## Verification
The embedded properties check, on every cycle, the local rules: a busy carrier or a failed draw never starts a transmission, full duplex always does, a settings write leaves the slot counter at 1, bytes move only with sink space, and idle follows tail only with feedback low. They also check that a framer pause keeps the data state, that an offered frame pulls the tail back to data, and that each rising key edge adds exactly one to the counter. The order and number of bytes on the sink depend on whole sequences of states, and only the bench scenarios can show them. These cover exact preamble and tail lengths, the tick on which key-up happens, calibration zeros ahead of a frame, back-to-back frames, and a resumed tail.

// File: rtl/tkc_pkg.sv
package tkc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_KEYUP = 2'd1,
    ST_DATA  = 2'd2,
    ST_TAIL  = 2'd3
  } tkc_state_e;

  localparam logic [7:0] FLAG_BYTE = 8'h7E;
  localparam logic [7:0] CAL_BYTE  = 8'h00;

  localparam int DEF_TXDELAY  = 20;
  localparam int DEF_TXTAIL   = 2;
  localparam int DEF_SLOTTIME = 10;
  localparam int DEF_PERSIST  = 40;

  // bit/s * 10 ms / 8 bits = bit/s / 800 bytes per 10 ms unit
  localparam int TENMS_DIV = 800;

  function automatic logic [31:0] tenms_to_flags(input logic [31:0] tenms,
                                                 input logic [31:0] rate);
    logic [31:0] prod;
    prod = tenms * rate;
    return prod / 32'(TENMS_DIV);
  endfunction

endpackage

// File: rtl/tkc_cfg_regs.sv
module tkc_cfg_regs #(
  parameter int PAR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PAR_W-1:0] wr_txdelay,
  input  logic [PAR_W-1:0] wr_txtail,
  input  logic [PAR_W-1:0] wr_slottime,
  input  logic [PAR_W-1:0] wr_persist,
  input  logic             wr_fulldup,
  output logic [PAR_W-1:0] txdelay,
  output logic [PAR_W-1:0] txtail,
  output logic [PAR_W-1:0] slottime,
  output logic [PAR_W-1:0] persist,
  output logic             fulldup
);
  import tkc_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txdelay  <= PAR_W'(DEF_TXDELAY);
      txtail   <= PAR_W'(DEF_TXTAIL);
      slottime <= PAR_W'(DEF_SLOTTIME);
      persist  <= PAR_W'(DEF_PERSIST);
      fulldup  <= 1'b0;
    end else if (wr_en) begin
      txdelay  <= wr_txdelay;
      txtail   <= wr_txtail;
      slottime <= wr_slottime;
      persist  <= wr_persist;
      fulldup  <= wr_fulldup;
    end
  end

endmodule

// File: rtl/tkc_csma_gate.sv
module tkc_csma_gate #(
  parameter int PAR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,        // idle, frame offered, no calibration
  input  logic             fulldup,
  input  logic             chan_busy,
  input  logic             slot_tick,
  input  logic [7:0]       rnd_val,
  input  logic [PAR_W-1:0] persist,
  input  logic [PAR_W-1:0] slottime,
  input  logic             cfg_load,
  output logic             start_go
);
  import tkc_pkg::*;

  logic [PAR_W-1:0] slot_cnt;
  logic             slot_reload;
  logic             slot_dec;
  logic             slot_expired;
  logic             draw_pass;

  assign slot_expired = (slot_cnt <= PAR_W'(1));
  assign draw_pass    = (PAR_W'(rnd_val) <= persist);

  always_comb begin
    start_go    = 1'b0;
    slot_reload = 1'b0;
    slot_dec    = 1'b0;
    if (arm) begin
      if (fulldup) begin
        start_go = 1'b1;
      end else if (chan_busy) begin
        slot_reload = 1'b1;
      end else if (slot_tick) begin
        if (slot_expired) begin
          slot_reload = 1'b1;
          start_go    = draw_pass;
        end else begin
          slot_dec = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           slot_cnt <= PAR_W'(DEF_SLOTTIME);
    else if (cfg_load)    slot_cnt <= PAR_W'(1);
    else if (slot_reload) slot_cnt <= slottime;
    else if (slot_dec)    slot_cnt <= slot_cnt - PAR_W'(1);
  end

  AST_BUSY_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !fulldup && chan_busy) |-> !start_go) else $error("busy defer"); // R2

  AST_BUSY_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !fulldup && chan_busy && !cfg_load) |=> (slot_cnt == $past(slottime))) else $error("busy reload"); // R2

  AST_PERSIST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_go && !fulldup) |-> (PAR_W'(rnd_val) <= persist)) else $error("persist"); // R3

  AST_TICK_NEEDED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_go && !fulldup) |-> slot_tick) else $error("tick"); // R3

  AST_FULLDUP_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && fulldup) |-> start_go) else $error("full duplex"); // R4

  AST_CFG_SLOT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (slot_cnt == PAR_W'(1))) else $error("cfg slot"); // R12

endmodule

// File: rtl/tkc_seq.sv
module tkc_seq #(
  parameter int PAR_W = 8,
  parameter int BR_W  = 20,
  parameter int CAL_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BR_W-1:0]  bit_rate,
  input  logic [PAR_W-1:0] txdelay,
  input  logic [PAR_W-1:0] txtail,
  input  logic             ptt_fb,
  input  logic             cal_we,
  input  logic [CAL_W-1:0] cal_bytes,
  input  logic             frm_valid,
  input  logic [7:0]       frm_data,
  input  logic             frm_last,
  input  logic             out_space,
  input  logic             start_go,
  output logic             csma_arm,
  output logic             frm_ready,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             ptt,
  output logic [CNT_W-1:0] keyup_count
);
  import tkc_pkg::*;

  localparam int FLG_W = BR_W + PAR_W;

  tkc_state_e       state;
  logic [FLG_W-1:0] flag_cnt;
  logic [CAL_W-1:0] cal_cnt;
  logic             in_frame;

  // named internal events
  logic flags_left;
  logic emit_flag;
  logic emit_cal;
  logic pass_byte;
  logic frame_gap;
  logic tail_done;

  function automatic logic [FLG_W-1:0] to_flags(input logic [PAR_W-1:0] tenms,
                                                 input logic [BR_W-1:0]  rate);
    return FLG_W'(tenms_to_flags(32'(tenms), 32'(rate)));
  endfunction

  assign flags_left = (flag_cnt != '0);
  assign emit_flag  = out_space && flags_left &&
                      ((state == ST_KEYUP) || (state == ST_TAIL && !frm_valid));
  assign emit_cal   = out_space && (state == ST_IDLE) && (cal_cnt != '0);
  assign pass_byte  = out_space && (state == ST_DATA) && frm_valid;
  assign frame_gap  = (state == ST_DATA) && !frm_valid && !in_frame;
  assign tail_done  = (state == ST_TAIL) && !frm_valid && !flags_left && !ptt_fb;

  assign csma_arm  = (state == ST_IDLE) && (cal_cnt == '0) && frm_valid;
  assign frm_ready = pass_byte;
  assign out_valid = emit_flag || emit_cal || pass_byte;
  assign out_data  = pass_byte ? frm_data : (emit_cal ? CAL_BYTE : FLAG_BYTE);
  assign ptt       = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_cnt <= '0;
    end else if (cal_we) begin
      cal_cnt <= cal_bytes;
    end else if (emit_cal) begin
      cal_cnt <= cal_cnt - CAL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      flag_cnt    <= '0;
      in_frame    <= 1'b0;
      keyup_count <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start_go) begin
            state       <= ST_KEYUP;
            flag_cnt    <= to_flags(txdelay, bit_rate);
            in_frame    <= 1'b0;
            keyup_count <= keyup_count + CNT_W'(1);
          end
        end
        ST_KEYUP: begin
          if (!flags_left) begin
            state <= ST_DATA;
          end else if (emit_flag) begin
            flag_cnt <= flag_cnt - FLG_W'(1);
            if (flag_cnt == FLG_W'(1)) state <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (pass_byte) begin
            in_frame <= !frm_last;
          end else if (frame_gap) begin
            state    <= ST_TAIL;
            flag_cnt <= to_flags(txtail, bit_rate);
          end
        end
        ST_TAIL: begin
          if (frm_valid) begin
            state <= ST_DATA;
          end else if (emit_flag) begin
            flag_cnt <= flag_cnt - FLG_W'(1);
          end else if (tail_done) begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_OUT_NEEDS_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_space) else $error("space"); // R13

  AST_READY_WHILE_KEYED: assert property (@(posedge clk) disable iff (!rst_n)
    frm_ready |-> (ptt && out_valid && out_data == frm_data)) else $error("ready"); // R13

  AST_KEYUP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ptt) |-> (keyup_count == $past(keyup_count) + CNT_W'(1))) else $error("keyup count"); // R11

  AST_COUNT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(ptt) |-> $stable(keyup_count)) else $error("count steady"); // R11

  AST_TAIL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && $past(state) == ST_TAIL) |-> !$past(ptt_fb)) else $error("release"); // R9

  AST_CAL_PRECEDENCE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && cal_cnt != '0) |=> !ptt) else $error("cal precedence"); // R10

  AST_PAUSE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && in_frame && !frm_valid) |=> (state == ST_DATA)) else $error("pause"); // R6

  AST_TAIL_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TAIL && frm_valid) |=> (state == ST_DATA && ptt)) else $error("resume"); // R8

endmodule

// File: rtl/tx_key_ctrl.sv
module tx_key_ctrl #(
  parameter int PAR_W = 8,
  parameter int BR_W  = 20,
  parameter int CAL_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_busy,
  input  logic             ptt_fb,
  input  logic             slot_tick,
  input  logic [7:0]       rnd_val,
  input  logic             cfg_we,
  input  logic [PAR_W-1:0] cfg_txdelay,
  input  logic [PAR_W-1:0] cfg_txtail,
  input  logic [PAR_W-1:0] cfg_slottime,
  input  logic [PAR_W-1:0] cfg_persist,
  input  logic             cfg_fulldup,
  input  logic [BR_W-1:0]  bit_rate,
  input  logic             cal_we,
  input  logic [CAL_W-1:0] cal_bytes,
  input  logic             frm_valid,
  input  logic [7:0]       frm_data,
  input  logic             frm_last,
  output logic             frm_ready,
  input  logic             out_space,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             ptt,
  output logic [CNT_W-1:0] keyup_count
);

  logic [PAR_W-1:0] txdelay;
  logic [PAR_W-1:0] txtail;
  logic [PAR_W-1:0] slottime;
  logic [PAR_W-1:0] persist;
  logic             fulldup;
  logic             csma_arm;
  logic             start_go;

  tkc_cfg_regs #(.PAR_W(PAR_W)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (cfg_we),
    .wr_txdelay  (cfg_txdelay),
    .wr_txtail   (cfg_txtail),
    .wr_slottime (cfg_slottime),
    .wr_persist  (cfg_persist),
    .wr_fulldup  (cfg_fulldup),
    .txdelay     (txdelay),
    .txtail      (txtail),
    .slottime    (slottime),
    .persist     (persist),
    .fulldup     (fulldup)
  );

  tkc_csma_gate #(.PAR_W(PAR_W)) u_csma (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (csma_arm),
    .fulldup   (fulldup),
    .chan_busy (chan_busy),
    .slot_tick (slot_tick),
    .rnd_val   (rnd_val),
    .persist   (persist),
    .slottime  (slottime),
    .cfg_load  (cfg_we),
    .start_go  (start_go)
  );

  tkc_seq #(
    .PAR_W (PAR_W),
    .BR_W  (BR_W),
    .CAL_W (CAL_W),
    .CNT_W (CNT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_rate    (bit_rate),
    .txdelay     (txdelay),
    .txtail      (txtail),
    .ptt_fb      (ptt_fb),
    .cal_we      (cal_we),
    .cal_bytes   (cal_bytes),
    .frm_valid   (frm_valid),
    .frm_data    (frm_data),
    .frm_last    (frm_last),
    .out_space   (out_space),
    .start_go    (start_go),
    .csma_arm    (csma_arm),
    .frm_ready   (frm_ready),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .ptt         (ptt),
    .keyup_count (keyup_count)
  );

endmodule

// File: tb/sim_tx_key_ctrl.sv
`timescale 1ns/1ps
module sim_tx_key_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chan_busy = 1'b0;
  logic        ptt_fb = 1'b0;
  logic        slot_tick = 1'b0;
  logic [7:0]  rnd_val = 8'd0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_txdelay = 8'd20;
  logic [7:0]  cfg_txtail = 8'd2;
  logic [7:0]  cfg_slottime = 8'd10;
  logic [7:0]  cfg_persist = 8'd40;
  logic        cfg_fulldup = 1'b0;
  logic [19:0] bit_rate = 20'd1200;
  logic        cal_we = 1'b0;
  logic [15:0] cal_bytes = 16'd0;
  logic        frm_valid = 1'b0;
  logic [7:0]  frm_data = 8'd0;
  logic        frm_last = 1'b0;
  logic        frm_ready;
  logic        out_space = 1'b1;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        ptt;
  logic [15:0] keyup_count;

  int checks = 0;
  int errors = 0;
  int cyc_no = 0;

  logic [8:0] fq[$];      // framer source: {last, data}
  logic [7:0] exp_q[$];   // scoreboard: expected sink bytes
  string      tag_q[$];
  logic       acc = 1'b0;
  logic       stall = 1'b0;
  logic       bp_en = 1'b0;

  // 1200 bit/s: 20 units -> 30 flags, 2 units -> 3 flags
  localparam int PRE_FLAGS  = 30;
  localparam int TAIL_FLAGS = 3;

  always #2.5 clk = ~clk;

  tx_key_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .chan_busy(chan_busy), .ptt_fb(ptt_fb),
    .slot_tick(slot_tick), .rnd_val(rnd_val), .cfg_we(cfg_we),
    .cfg_txdelay(cfg_txdelay), .cfg_txtail(cfg_txtail),
    .cfg_slottime(cfg_slottime), .cfg_persist(cfg_persist),
    .cfg_fulldup(cfg_fulldup), .bit_rate(bit_rate), .cal_we(cal_we),
    .cal_bytes(cal_bytes), .frm_valid(frm_valid), .frm_data(frm_data),
    .frm_last(frm_last), .frm_ready(frm_ready), .out_space(out_space),
    .out_valid(out_valid), .out_data(out_data), .ptt(ptt),
    .keyup_count(keyup_count)
  );

  task automatic chk(input logic ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push_flags(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(8'h7E);
      tag_q.push_back(tag);
    end
  endtask

  task automatic push_zeros(input int n);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(8'h00);
      tag_q.push_back("R10 calibration zero");
    end
  endtask

  task automatic push_frame(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = seed ^ 8'(i * 29 + 3);
      fq.push_back({(i == n - 1), b});
      exp_q.push_back(b);
      tag_q.push_back("R6 frame byte");
    end
  endtask

  task automatic tick();
    slot_tick = 1'b1;
    cyc(1);
    slot_tick = 1'b0;
  endtask

  task automatic write_cfg(input logic [7:0] dly, input logic [7:0] tl,
                           input logic [7:0] st, input logic [7:0] ps, input logic fd);
    cfg_txdelay = dly; cfg_txtail = tl; cfg_slottime = st;
    cfg_persist = ps; cfg_fulldup = fd; cfg_we = 1'b1;
    cyc(1);
    cfg_we = 1'b0;
  endtask

  task automatic wait_drain(input string req);
    int n = 0;
    while (exp_q.size() != 0 && n < 3000) begin cyc(1); n++; end
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (ptt && n < 200) begin cyc(1); n++; end
    chk(!ptt, req, int'(ptt), 0);
  endtask

  // framer and sink model, driven after the edge
  always @(posedge clk) begin
    #2;
    cyc_no++;
    if (acc) void'(fq.pop_front());
    frm_valid = (fq.size() != 0) && !stall;
    frm_data  = (fq.size() != 0) ? fq[0][7:0] : 8'h00;
    frm_last  = (fq.size() != 0) ? fq[0][8] : 1'b0;
    out_space = bp_en ? ((cyc_no % 3) != 0) : 1'b1;
  end

  // scoreboard monitor, mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      acc = frm_valid && frm_ready;
      if (out_valid) begin
        if (!out_space) chk(1'b0, "R13 valid without space", 1, 0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected byte", int'(out_data), -1);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(out_data == e, t, int'(out_data), int'(e));
        end
      end
    end else begin
      acc = 1'b0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1-wide: actual %0d cycles expected fewer", 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    chk(!ptt, "R1 ptt after reset", int'(ptt), 0);
    chk(!out_valid, "R1 no byte after reset", int'(out_valid), 0);
    chk(keyup_count == 0, "R1 keyup_count after reset", int'(keyup_count), 0);

    // S1: default settings, half duplex
    chan_busy = 1'b1;
    push_flags(PRE_FLAGS, "R5 preamble flag");
    push_frame(4, 8'hA5);
    push_flags(TAIL_FLAGS, "R7 tail flag");
    for (int i = 0; i < 6; i++) begin tick(); cyc(2); end
    chk(!ptt, "R2 busy carrier defers", int'(ptt), 0);
    chan_busy = 1'b0;
    rnd_val = 8'd41;
    for (int i = 0; i < 10; i++) tick();
    chk(!ptt, "R3 draw above persistence", int'(ptt), 0);
    rnd_val = 8'd40;
    for (int i = 0; i < 9; i++) tick();
    chk(!ptt, "R3 slot count not expired", int'(ptt), 0);
    tick();
    chk(ptt, "R3 key-up on slot expiry with draw equal", int'(ptt), 1);
    chk(keyup_count == 1, "R11 first key-up", int'(keyup_count), 1);
    ptt_fb = 1'b1;
    wait_drain("R7 first transmission");
    cyc(10);
    chk(ptt, "R9 key held while feedback high", int'(ptt), 1);
    ptt_fb = 1'b0;
    cyc(1);
    chk(!ptt, "R9 release after feedback low", int'(ptt), 0);

    // S2: full duplex, back-pressure, back-to-back frames, framer pause
    write_cfg(8'd20, 8'd2, 8'd10, 8'd40, 1'b1);
    chan_busy = 1'b1;
    bp_en = 1'b1;
    push_flags(PRE_FLAGS, "R5 preamble flag");
    push_frame(5, 8'h3C);
    push_frame(3, 8'hC3);
    push_flags(TAIL_FLAGS, "R7 tail flag");
    cyc(1);
    chk(ptt, "R4 full duplex keys despite carrier", int'(ptt), 1);
    while (fq.size() > 6) cyc(1);
    stall = 1'b1;
    cyc(8);
    chk(ptt, "R6 pause keeps transmission", int'(ptt), 1);
    stall = 1'b0;
    wait_drain("R6 back-to-back frames");
    wait_idle("R9 idle after tail");
    chk(keyup_count == 2, "R11 second key-up", int'(keyup_count), 2);
    bp_en = 1'b0;
    chan_busy = 1'b0;

    // S3: frame arriving in the tail
    ptt_fb = 1'b1;
    push_flags(PRE_FLAGS, "R5 preamble flag");
    push_frame(3, 8'h11);
    push_flags(TAIL_FLAGS, "R7 tail flag");
    wait_drain("R7 tail before resume");
    cyc(5);
    push_frame(2, 8'h77);
    push_flags(TAIL_FLAGS, "R8 tail after resume");
    wait_drain("R8 resumed frame");
    chk(keyup_count == 3, "R8 no new key-up on resume", int'(keyup_count), 3);
    ptt_fb = 1'b0;
    wait_idle("R9 idle after resumed tail");

    // S4: calibration ahead of a pending frame
    cal_bytes = 16'd6;
    cal_we = 1'b1;
    cyc(1);
    cal_we = 1'b0;
    push_zeros(6);
    push_flags(PRE_FLAGS, "R5 preamble flag");
    push_frame(2, 8'h5A);
    push_flags(TAIL_FLAGS, "R7 tail flag");
    cyc(2);
    chk(!ptt, "R10 no key-up during calibration", int'(ptt), 0);
    wait_drain("R10 calibration then frame");
    wait_idle("R9 idle after calibration frame");
    chk(keyup_count == 4, "R11 fourth key-up", int'(keyup_count), 4);

    // S5: settings write forces slot counter, zero preamble
    chan_busy = 1'b1;
    cyc(3);
    write_cfg(8'd0, 8'd2, 8'd10, 8'd255, 1'b0);
    chan_busy = 1'b0;
    push_frame(2, 8'hE1);
    push_flags(TAIL_FLAGS, "R7 tail flag");
    cyc(3);
    chk(!ptt, "R12 no key-up without tick", int'(ptt), 0);
    rnd_val = 8'd255;
    tick();
    chk(ptt, "R12 first tick after write decides", int'(ptt), 1);
    wait_drain("R5 zero preamble");
    wait_idle("R9 final idle");
    chk(fq.size() == 0, "R6 framer drained", fq.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule